// File: doc/BRIEF.md
# Interrupt status and mask controller

This block gathers interrupt requests from up to sixteen peripheral sources into a status register. It qualifies them with a mask register and drives a single pending-interrupt line toward the processor. Each source sets its status bit with a one-cycle pulse, and the bit stays set until software acknowledges it. Software acknowledges by writing the status register: the written word is ANDed into the held value, so a bit written as 0 is cleared and a bit written as 1 is left alone. A dedicated DMA request input feeds status bit 3.

Software sets the mask register by writing a new value over it. Whenever a mask write exposes a bit that is already set in status, the block emits a one-cycle recheck pulse. This tells the processor side to evaluate interrupts again at once rather than at its next natural polling point. Both registers are reached through a simple 32-bit register port with a byte address. Only the low 16 bits of a write are used, and reads come back zero-extended.

Top module: `irq_aggregator`

## Requirements
- R1: A one-cycle pulse on bit i of `srcSet` makes status bit i read as 1 from the next cycle on, and the bit stays set until software clears it.
- R2: A write to the status register at byte offset 0x70 sets status to the old status ANDed with write data bits 15:0. A bit written as 0 is cleared and a bit written as 1 keeps its value.
- R3: A write to the mask register at byte offset 0x74 replaces the mask with write data bits 15:0.
- R4: `irqPending` is 1 exactly when some bit is set in both status and mask. It reflects a status or mask change from the cycle after the edge that stored it.
- R5: A mask write whose new value shares a set bit with status, as held before that write, raises `recheckPulse` for exactly one cycle, the cycle after the write. A mask write with no overlap leaves `recheckPulse` low.
- R6: Reset clears status and mask, so `irqPending` and `recheckPulse` are low after reset.
- R7: A pulse on `dmaIrq` sets status bit 3.
- R8: When a source pulse and a status write that clears the same bit fall in one cycle, the bit ends up set.
- R9: Write data bits 31:16 have no effect. A read of offset 0x70 or 0x74 returns the register in bits 15:0 with bits 31:16 at 0.
- R10: A write to any other offset changes neither register, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the addressed register |
| srcSet | input | 16 | Per-source set pulses |
| dmaIrq | input | 1 | DMA interrupt set pulse for status bit 3 |
| irqPending | output | 1 | Pending-interrupt line to the processor |
| recheckPulse | output | 1 | One-cycle pulse after a mask write that exposes a pending bit |

## Verification
The checker verifies on every cycle that set pulses land and stick, including against a simultaneous acknowledge. It also checks that an acknowledge leaves no bit set that the write cleared, that a mask write loads exactly the low half-word, and that the DMA input reaches bit 3. It further checks that a recheck pulse only follows a mask write and that writes to unmapped offsets leave both registers untouched. The bench scenarios are needed to show the values actually read back over the port: zero extension, zero reads of unmapped offsets and the reset state. They also show the timing of `irqPending`, and that a mask write with no overlap gives no recheck pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Decoded register strobes passed from control to datapath
  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic rdStatus;
    logic rdMask;
  } regStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int STATUS_OFS = 'h70,
  parameter int MASK_OFS   = 'h74
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_A   = ADDR_W'(MASK_OFS);

  logic hitStatus;
  logic hitMask;

  always_comb begin
    hitStatus        = busSel && (busAddr == STATUS_A);
    hitMask          = busSel && (busAddr == MASK_A);
    strobes.wrStatus = hitStatus && busWr;
    strobes.wrMask   = hitMask && busWr;
    strobes.rdStatus = hitStatus && !busWr;
    strobes.rdMask   = hitMask && !busWr;
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int DMA_BIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobes_t        strobes,
  input  logic [NUM_SRC-1:0] wdataLo,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic               dmaIrq,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqPending,
  output logic               recheckPulse,
  output logic [DATA_W-1:0]  rdata
);
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] statusD;

  always_comb begin
    setVec          = srcSet;
    setVec[DMA_BIT] = srcSet[DMA_BIT] | dmaIrq;
  end

  // Per-bit next status: acknowledge by AND, a set pulse overrides it
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      statusD[i] = (strobes.wrStatus ? (statusQ[i] & wdataLo[i]) : statusQ[i]) | setVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statusQ      <= '0;
      maskQ        <= '0;
      recheckPulse <= 1'b0;
    end else begin
      statusQ      <= statusD;
      if (strobes.wrMask) maskQ <= wdataLo;
      recheckPulse <= strobes.wrMask && |(wdataLo & statusQ);
    end
  end

  assign irqPending = |(statusQ & maskQ);

  always_comb begin
    rdata = '0;
    if (strobes.rdStatus)    rdata = DATA_W'(statusQ);
    else if (strobes.rdMask) rdata = DATA_W'(maskQ);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 16,
  parameter int DMA_BIT    = 3,
  parameter int STATUS_OFS = 'h70,
  parameter int MASK_OFS   = 'h74
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic               dmaIrq,
  output logic               irqPending,
  output logic               recheckPulse
);
  regStrobes_t        strobes;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               unusedWdataHi;

  assign unusedWdataHi = ^busWdata[DATA_W-1:NUM_SRC];

  irq_agg_ctrl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobes(strobes)
  );

  irq_agg_dp #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .DMA_BIT(DMA_BIT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .wdataLo     (busWdata[NUM_SRC-1:0]),
    .srcSet      (srcSet),
    .dmaIrq      (dmaIrq),
    .statusQ     (statusQ),
    .maskQ       (maskQ),
    .irqPending  (irqPending),
    .recheckPulse(recheckPulse),
    .rdata       (busRdata)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_SRC    = 16,
  parameter int DMA_BIT    = 3,
  parameter int STATUS_OFS = 'h70,
  parameter int MASK_OFS   = 'h74
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busSel,
  input logic               busWr,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] srcSet,
  input logic               dmaIrq,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               recheckPulse
);
  logic chkWrStat, chkWrMask, chkWrOther, noSet;
  assign chkWrStat  = busSel && busWr && (busAddr == ADDR_W'(STATUS_OFS));
  assign chkWrMask  = busSel && busWr && (busAddr == ADDR_W'(MASK_OFS));
  assign chkWrOther = busSel && busWr && !chkWrStat && !chkWrMask;
  assign noSet      = (srcSet == '0) && !dmaIrq;

  AST_SRC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|srcSet) |=> ((statusQ & $past(srcSet)) == $past(srcSet))); // R1

  AST_SRC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (chkWrStat && |srcSet) |=> ((statusQ & $past(srcSet)) == $past(srcSet))); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (chkWrStat && noSet) |=> ((statusQ & ~$past(busWdata[NUM_SRC-1:0])) == '0)); // R2

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    chkWrMask |=> (maskQ == $past(busWdata[NUM_SRC-1:0]))); // R3

  AST_RECHECK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    recheckPulse |-> $past(chkWrMask)); // R5

  AST_DMA_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    dmaIrq |=> statusQ[DMA_BIT]); // R7

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (chkWrOther && noSet) |=> ($stable(statusQ) && $stable(maskQ))); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .DMA_BIT(DMA_BIT),
  .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .srcSet(srcSet), .dmaIrq(dmaIrq), .statusQ(statusQ),
  .maskQ(maskQ), .recheckPulse(recheckPulse)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam logic [7:0] A_STAT = 8'h70;
  localparam logic [7:0] A_MASK = 8'h74;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] srcSet = '0;
  logic        dmaIrq = 1'b0;
  logic        irqPending;
  logic        recheckPulse;

  int checks = 0;
  int errors = 0;
  logic [15:0] mStat = '0;
  logic [15:0] mMask = '0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcSet(srcSet), .dmaIrq(dmaIrq),
    .irqPending(irqPending), .recheckPulse(recheckPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares mid low phase
  always @(negedge clk) begin
    #5;
    if (busSel && !busWr && expQ.size() > 0) begin
      check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  // Driver for reads: pushes expected value onto the scoreboard
  task automatic rd(input logic [7:0] addr, input string req);
    logic [31:0] e;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr; busWdata = '0;
    srcSet = '0; dmaIrq = 1'b0;
    e = (addr == A_STAT) ? {16'h0, mStat} : (addr == A_MASK) ? {16'h0, mMask} : 32'h0;
    expQ.push_back(e);
    tagQ.push_back(req);
  endtask

  // One cycle of stimulus, then check pending and recheck after the edge
  task automatic step(input logic sel, input logic [7:0] addr, input logic [31:0] wd,
                      input logic [15:0] src, input logic dma, input string req);
    logic expRe;
    logic [15:0] ns;
    @(negedge clk);
    busSel = sel; busWr = sel; busAddr = addr; busWdata = wd;
    srcSet = src; dmaIrq = dma;
    expRe = sel && (addr == A_MASK) && |(wd[15:0] & mStat);
    ns = (sel && addr == A_STAT) ? (mStat & wd[15:0]) : mStat;
    ns = ns | src;
    ns[3] = ns[3] | dma;
    mStat = ns;
    if (sel && addr == A_MASK) mMask = wd[15:0];
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; srcSet = '0; dmaIrq = 1'b0;
    #5;
    check({req, " pending"}, 32'(irqPending), 32'(|(mStat & mMask)));
    check({req, " recheck"}, 32'(recheckPulse), 32'(expRe));
  endtask

  task automatic idle();
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; srcSet = '0; dmaIrq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R6 pending after reset", 32'(irqPending), 32'h0);
    check("R6 recheck after reset", 32'(recheckPulse), 32'h0);
    rd(A_STAT, "R6 status after reset");
    rd(A_MASK, "R6 mask after reset");

    step(1'b0, 8'h00, 32'h0, 16'h0081, 1'b0, "R1 sources set");
    rd(A_STAT, "R1 status sticky");
    step(1'b1, A_MASK, 32'h0000_0001, 16'h0, 1'b0, "R5 unmask pending bit");
    rd(A_MASK, "R3 mask replaced");
    step(1'b1, A_MASK, 32'h0000_0100, 16'h0, 1'b0, "R5 no overlap");
    rd(A_MASK, "R3 mask replaced again");
    step(1'b1, A_MASK, 32'h0000_0080, 16'h0, 1'b0, "R4 pending via bit7");
    step(1'b1, A_STAT, 32'h0000_FF7F, 16'h0, 1'b0, "R2 ack bit7");
    rd(A_STAT, "R2 status after ack");
    step(1'b0, 8'h00, 32'h0, 16'h0, 1'b1, "R7 dma pulse");
    rd(A_STAT, "R7 dma sets bit3");
    step(1'b1, A_STAT, 32'h0000_FFFF, 16'h0, 1'b0, "R2 write ones keeps");
    rd(A_STAT, "R2 status unchanged by ones");
    step(1'b1, A_STAT, 32'h0000_0000, 16'h0004, 1'b0, "R8 set beats ack");
    rd(A_STAT, "R8 bit2 kept, rest cleared");
    step(1'b1, A_MASK, 32'hFFFF_0004, 16'h0, 1'b0, "R9 upper bits ignored");
    rd(A_MASK, "R9 mask zero-extended");
    rd(A_STAT, "R9 status zero-extended");
    step(1'b1, 8'h78, 32'h0000_0000, 16'h0, 1'b0, "R10 unmapped write");
    rd(A_STAT, "R10 status untouched");
    rd(A_MASK, "R10 mask untouched");
    rd(8'h7C, "R10 unmapped read zero");
    step(1'b1, A_STAT, 32'h0000_FFFB, 16'h0, 1'b0, "R4 pending drops");
    step(1'b0, 8'h00, 32'h0, 16'hA000, 1'b0, "R4 masked source no pending");
    rd(A_STAT, "R1 upper sources");

    @(negedge clk);
    rst_n = 1'b0;
    mStat = '0; mMask = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R6 pending after mid reset", 32'(irqPending), 32'h0);
    rd(A_STAT, "R6 status after mid reset");
    rd(A_MASK, "R6 mask after mid reset");
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule